// File: doc/BRIEF.md
# Serial Frame CRC Generator and Checker

This block adds cyclic-redundancy protection to a full-duplex, frame-oriented serial link. Two bit-serial accumulators run side by side. The transmit accumulator takes in every data bit that leaves on the serial output. The receive accumulator takes in every data bit that arrives on the serial input. Both shift most-significant bit first, start from zero, apply a polynomial that is supplied as an input, and apply no final inversion. The CRC has the same width as a data frame.

Once the data sequence is over, the block sends its transmit CRC as one extra frame. That step is automatic when a programmed data-frame count is reached. In manual operation it happens when a one-cycle CRC-next request is raised during the last data frame. On the receive side the CRC frame goes into the receive buffer like any other frame. At the end of that frame it is compared with the receive accumulator, which holds the value it had before the CRC frame began. A mismatch sets a sticky error flag, and only an explicit write of 0 clears it.

Serial bit timing is supplied as a single-cycle `bit_tick` strobe in the system clock domain. In slave mode the accumulators keep running on every tick while CRC is enabled, whatever the chip-select and link-enable levels are. Both sides are resynchronised by taking `crc_en` low and then high again.

Top module: `spi_frame_crc`

## Requirements
- R1: Each accumulator step computes fb = acc[MSB] xor bit, then acc = (acc << 1) xor (fb ? poly : 0). Bits are taken MSB first, the start value is 0 and there is no final inversion. For an 8-bit frame, one frame step equals acc ^= data followed by eight conditional shift-and-xor steps.
- R2: Exactly one CRC frame follows the data sequence. During that frame `tx_bit` sends the transmit CRC of all data bits sent, MSB first, and `crc_frame` is 1. `crc_frame` returns to 0 after that frame ends.
- R3: When `auto_mode` = 1 and `tx_count` = N (N ≥ 1), the frame that follows the N-th data frame is the CRC frame, with no CRC-next request needed.
- R4: When `auto_mode` = 0, no CRC frame is inserted without a request. A one-cycle `crc_next` pulse makes the frame that follows the current data frame the CRC frame.
- R5: Every received frame, the CRC frame included, is written to `rx_buf` (first bit received lands in the MSB), and `rx_ready` is set at the frame end. `rx_ready` stays set until a `rx_read` pulse.
- R6: At the end of the CRC frame, the received word is compared with the receive accumulator as it stood before the CRC frame. A mismatch sets `crc_err`, and a match leaves it unchanged.
- R7: `crc_err` is sticky. It clears only when `err_wr` = 1 with `err_wdata` = 0, and a write of 1 has no effect on a set flag.
- R8: While `crc_en` = 0 both accumulators are held at 0, so taking the enable low and then high restarts both from 0.
- R9: With `slave_mode` = 1 and `crc_en` = 1, both accumulators update on every `bit_tick` outside the CRC frame, even when `cs_n` = 1 or `spi_en` = 0. Framing and the receive buffer advance only when `spi_en` = 1 and `cs_n` = 0.
- R10: With `slave_mode` = 0, ticks are ignored while `spi_en` = 0: neither the accumulators nor the framing change. `cs_n` has no effect.
- R11: After reset `rx_buf` = 0, `rx_ready` = 0, `crc_err` = 0 and `crc_frame` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| slave_mode | input | 1 | 1 = slave, 0 = master |
| spi_en | input | 1 | Link enable |
| cs_n | input | 1 | Chip select, active low (slave only) |
| crc_en | input | 1 | CRC calculation enable; low clears accumulators |
| auto_mode | input | 1 | 1 = insert CRC after `tx_count` data frames |
| poly | input | W | CRC polynomial without the top term |
| tx_count | input | CNT_W | Data frames per transaction in automatic mode |
| crc_next | input | 1 | Pulse: next frame carries the CRC (manual mode) |
| bit_tick | input | 1 | One-cycle strobe per serial bit |
| tx_data | input | W | Next data frame to send |
| tx_bit | output | 1 | Serial output, valid before each tick |
| rx_bit | input | 1 | Serial input, sampled on each tick |
| rx_read | input | 1 | Pulse: receive buffer read, clears `rx_ready` |
| rx_buf | output | W | Last received frame |
| rx_ready | output | 1 | Receive buffer holds an unread frame |
| err_wr | input | 1 | Write strobe for the error flag |
| err_wdata | input | 1 | Value written; only 0 clears |
| crc_err | output | 1 | Sticky CRC mismatch flag |
| crc_frame | output | 1 | Current frame is the CRC frame |

## Verification
Some behaviours are checked by assertions on every cycle: the error flag and receive-ready flag holding until their defined clear, both accumulators being zero while disabled, the receive accumulator freezing during the CRC frame and while a master is disabled, and the CRC frame starting only at a data-frame boundary after the programmed count. Only the bench scenarios can show the rest. These are the actual CRC values for several polynomials, error detection for every single-bit corruption position in a three-frame transfer, manual versus automatic insertion, and slave accumulators advancing on ticks that arrive while deselected or disabled.

// File: rtl/spi_crc_pkg.sv
package spi_crc_pkg;

   localparam int unsigned CRC_MAX_W = 32;

   typedef logic [CRC_MAX_W-1:0] crc_word_t;

   // one MSB-first division step of a width-w register
   function automatic crc_word_t crc_bit_step(input crc_word_t acc,
                                              input logic      din,
                                              input crc_word_t poly,
                                              input int unsigned w);
      crc_word_t mask;
      crc_word_t res;
      logic      fb;
      mask = (w >= CRC_MAX_W) ? '1 : ((crc_word_t'(1) << w) - 1);
      fb   = acc[w-1] ^ din;
      res  = (acc << 1) ^ (fb ? poly : '0);
      return res & mask;
   endfunction

endpackage

// File: rtl/crc_lfsr.sv
module crc_lfsr #(
   parameter int unsigned W        = 8,
   parameter bit          UNROLLED = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         step,
   input  logic         bit_in,
   input  logic [W-1:0] poly,
   output logic [W-1:0] acc
);
   import spi_crc_pkg::*;

   logic [W-1:0] nxt;

   generate
      if (W < 2 || W > CRC_MAX_W) begin : g_bad_w
         $error("crc_lfsr: W out of range");
      end
      if (UNROLLED) begin : g_taps
         logic fb;
         assign fb     = acc[W-1] ^ bit_in;
         assign nxt[0] = fb & poly[0];
         for (genvar i = 1; i < W; i++) begin : g_bit
            assign nxt[i] = acc[i-1] ^ (fb & poly[i]);
         end
      end else begin : g_func
         crc_word_t wide;
         assign wide = crc_bit_step(crc_word_t'(acc), bit_in, crc_word_t'(poly), W);
         assign nxt  = wide[W-1:0];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    acc <= '0;
      else if (clr)  acc <= '0;
      else if (step) acc <= nxt;
   end

   // R8: a disabled calculator sits at zero
   a_r8_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> acc == '0);

   // R1: no update without a step
   a_r1_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !clr && !step |=> $stable(acc));

endmodule

// File: rtl/spi_frame_seq.sv
module spi_frame_seq #(
   parameter int unsigned W     = 8,
   parameter int unsigned CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             slave_mode,
   input  logic             spi_en,
   input  logic             cs_n,
   input  logic             crc_en,
   input  logic             auto_mode,
   input  logic [CNT_W-1:0] tx_count,
   input  logic             crc_next,
   input  logic             bit_tick,
   output logic             active_tick,
   output logic             calc_tick,
   output logic             bit_first,
   output logic             frame_end,
   output logic             crc_phase
);
   localparam int unsigned BC_W = $clog2(W);
   localparam logic [BC_W-1:0] LAST_BIT = BC_W'(W - 1);

   generate
      if (CNT_W < 1 || CNT_W > 16) begin : g_bad_cnt
         $error("spi_frame_seq: CNT_W out of range");
      end
   endgenerate

   logic             framing;
   logic [BC_W-1:0]  bit_cnt;
   logic [CNT_W-1:0] data_cnt;
   logic [CNT_W-1:0] data_cnt_inc;
   logic             pend_q;
   logic             count_hit;
   logic             enter_crc;

   assign framing      = spi_en && (!slave_mode || !cs_n);
   assign active_tick  = bit_tick && framing;
   assign bit_first    = (bit_cnt == '0);
   assign frame_end    = active_tick && (bit_cnt == LAST_BIT);
   assign calc_tick    = bit_tick && crc_en && !crc_phase && (slave_mode || spi_en);
   assign data_cnt_inc = data_cnt + 1'b1;
   assign count_hit    = (data_cnt_inc == tx_count);
   assign enter_crc    = frame_end && !crc_phase && crc_en &&
                         (auto_mode ? count_hit : (pend_q || crc_next));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           bit_cnt <= '0;
      else if (!framing)    bit_cnt <= '0;
      else if (frame_end)   bit_cnt <= '0;
      else if (active_tick) bit_cnt <= bit_cnt + 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         data_cnt <= '0;
      else if (!spi_en)   data_cnt <= '0;
      else if (frame_end) data_cnt <= crc_phase ? '0 : data_cnt_inc;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                      crc_phase <= 1'b0;
      else if (!crc_en || !spi_en)     crc_phase <= 1'b0;
      else if (frame_end && crc_phase) crc_phase <= 1'b0;
      else if (enter_crc)              crc_phase <= 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         pend_q <= 1'b0;
      else if (!crc_en)   pend_q <= 1'b0;
      else if (enter_crc) pend_q <= 1'b0;
      else if (crc_next)  pend_q <= 1'b1;
   end

   // R2: the CRC frame starts only right after a frame boundary
   a_r2_enter_on_boundary: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(crc_phase) |-> $past(frame_end));

   // R2: the CRC frame is exactly one frame long
   a_r2_single_crc_frame: assert property (@(posedge clk) disable iff (!rst_n)
      crc_phase && frame_end |=> !crc_phase);

   // R3: automatic insertion only after the programmed count
   a_r3_auto_count: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(crc_phase) && $past(auto_mode) |-> $past(data_cnt_inc) == $past(tx_count));

   // R10: a disabled master does not advance its framing
   a_r10_master_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      !slave_mode && !spi_en |=> bit_cnt == '0);

endmodule

// File: rtl/spi_tx_shift.sv
module spi_tx_shift #(
   parameter int unsigned W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         active_tick,
   input  logic         bit_first,
   input  logic [W-1:0] load_word,
   output logic         tx_bit
);
   logic [W-1:0] shreg;

   assign tx_bit = bit_first ? load_word[W-1] : shreg[W-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           shreg <= '0;
      else if (active_tick) shreg <= bit_first ? (load_word << 1) : (shreg << 1);
   end

endmodule

// File: rtl/spi_rx_path.sv
module spi_rx_path #(
   parameter int unsigned W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         active_tick,
   input  logic         frame_end,
   input  logic         rx_bit,
   input  logic         crc_phase,
   input  logic         crc_en,
   input  logic [W-1:0] rx_acc,
   input  logic         rx_read,
   input  logic         err_wr,
   input  logic         err_wdata,
   output logic [W-1:0] rx_buf,
   output logic         rx_ready,
   output logic         crc_err
);
   logic [W-1:0] rx_sh;
   logic [W-1:0] rx_word;
   logic         mismatch;

   assign rx_word  = {rx_sh[W-2:0], rx_bit};
   assign mismatch = frame_end && crc_phase && crc_en && (rx_word != rx_acc);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           rx_sh <= '0;
      else if (active_tick) rx_sh <= rx_word;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         rx_buf <= '0;
      else if (frame_end) rx_buf <= rx_word;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         rx_ready <= 1'b0;
      else if (frame_end) rx_ready <= 1'b1;
      else if (rx_read)   rx_ready <= 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                   crc_err <= 1'b0;
      else if (mismatch)            crc_err <= 1'b1;
      else if (err_wr && !err_wdata) crc_err <= 1'b0;
   end

   // R5: ready holds until read
   a_r5_ready_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      rx_ready && !rx_read |=> rx_ready);

   // R6: a mismatching CRC frame raises the flag
   a_r6_mismatch_flags: assert property (@(posedge clk) disable iff (!rst_n)
      frame_end && crc_phase && crc_en && (rx_word != rx_acc) |=> crc_err);

   // R7: only a write of zero clears the flag
   a_r7_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      crc_err && !(err_wr && !err_wdata) |=> crc_err);

endmodule

// File: rtl/spi_frame_crc.sv
module spi_frame_crc #(
   parameter int unsigned W        = 8,
   parameter int unsigned CNT_W    = 8,
   parameter bit          UNROLLED = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             slave_mode,
   input  logic             spi_en,
   input  logic             cs_n,
   input  logic             crc_en,
   input  logic             auto_mode,
   input  logic [W-1:0]     poly,
   input  logic [CNT_W-1:0] tx_count,
   input  logic             crc_next,
   input  logic             bit_tick,
   input  logic [W-1:0]     tx_data,
   output logic             tx_bit,
   input  logic             rx_bit,
   input  logic             rx_read,
   output logic [W-1:0]     rx_buf,
   output logic             rx_ready,
   input  logic             err_wr,
   input  logic             err_wdata,
   output logic             crc_err,
   output logic             crc_frame
);
   generate
      if (W != 8 && W != 16) begin : g_bad_frame
         $error("spi_frame_crc: frame width must be 8 or 16");
      end
   endgenerate

   logic         active_tick;
   logic         calc_tick;
   logic         bit_first;
   logic         frame_end;
   logic         crc_phase;
   logic [W-1:0] tx_acc;
   logic [W-1:0] rx_acc;
   logic [W-1:0] load_word;

   assign crc_frame = crc_phase;
   assign load_word = crc_phase ? tx_acc : tx_data;

   spi_frame_seq #(.W(W), .CNT_W(CNT_W)) i_seq (
      .clk(clk), .rst_n(rst_n), .slave_mode(slave_mode), .spi_en(spi_en),
      .cs_n(cs_n), .crc_en(crc_en), .auto_mode(auto_mode), .tx_count(tx_count),
      .crc_next(crc_next), .bit_tick(bit_tick), .active_tick(active_tick),
      .calc_tick(calc_tick), .bit_first(bit_first), .frame_end(frame_end),
      .crc_phase(crc_phase)
   );

   spi_tx_shift #(.W(W)) i_tx (
      .clk(clk), .rst_n(rst_n), .active_tick(active_tick), .bit_first(bit_first),
      .load_word(load_word), .tx_bit(tx_bit)
   );

   crc_lfsr #(.W(W), .UNROLLED(UNROLLED)) i_tx_crc (
      .clk(clk), .rst_n(rst_n), .clr(!crc_en), .step(calc_tick),
      .bit_in(tx_bit), .poly(poly), .acc(tx_acc)
   );

   crc_lfsr #(.W(W), .UNROLLED(UNROLLED)) i_rx_crc (
      .clk(clk), .rst_n(rst_n), .clr(!crc_en), .step(calc_tick),
      .bit_in(rx_bit), .poly(poly), .acc(rx_acc)
   );

   spi_rx_path #(.W(W)) i_rx (
      .clk(clk), .rst_n(rst_n), .active_tick(active_tick), .frame_end(frame_end),
      .rx_bit(rx_bit), .crc_phase(crc_phase), .crc_en(crc_en), .rx_acc(rx_acc),
      .rx_read(rx_read), .err_wr(err_wr), .err_wdata(err_wdata),
      .rx_buf(rx_buf), .rx_ready(rx_ready), .crc_err(crc_err)
   );

   // R6: the compared receive value stays frozen through the CRC frame
   a_r6_rx_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      crc_phase && crc_en |=> $stable(rx_acc));

   // R2: the transmitted CRC value is frozen while it is sent
   a_r2_tx_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      crc_phase && crc_en |=> $stable(tx_acc));

   // R8: both calculators restart from zero
   a_r8_both_zero: assert property (@(posedge clk) disable iff (!rst_n)
      !crc_en |=> (tx_acc == '0) && (rx_acc == '0));

   // R10: a disabled master ignores ticks in its calculator
   a_r10_master_calc_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !slave_mode && !spi_en && crc_en |=> $stable(rx_acc) && $stable(tx_acc));

endmodule

// File: tb/test_spi_frame_crc.sv
module test_spi_frame_crc;
   localparam int W = 8;
   localparam int CNT_W = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic slave_mode = 1'b0, spi_en = 1'b0, cs_n = 1'b1, crc_en = 1'b0, auto_mode = 1'b1;
   logic [W-1:0] poly = 8'h07;
   logic [CNT_W-1:0] tx_count = '0;
   logic crc_next = 1'b0, bit_tick = 1'b0, rx_bit = 1'b0, rx_read = 1'b0;
   logic err_wr = 1'b0, err_wdata = 1'b0;
   logic [W-1:0] tx_data = '0;
   logic tx_bit, rx_ready, crc_err, crc_frame;
   logic [W-1:0] rx_buf;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   spi_frame_crc #(.W(W), .CNT_W(CNT_W)) i_spi_frame_crc (
      .clk(clk), .rst_n(rst_n), .slave_mode(slave_mode), .spi_en(spi_en), .cs_n(cs_n),
      .crc_en(crc_en), .auto_mode(auto_mode), .poly(poly), .tx_count(tx_count),
      .crc_next(crc_next), .bit_tick(bit_tick), .tx_data(tx_data), .tx_bit(tx_bit),
      .rx_bit(rx_bit), .rx_read(rx_read), .rx_buf(rx_buf), .rx_ready(rx_ready),
      .err_wr(err_wr), .err_wdata(err_wdata), .crc_err(crc_err), .crc_frame(crc_frame)
   );

   // frame-at-a-time model: xor in the byte, then eight conditional shifts
   function automatic logic [7:0] crc_byte(input logic [7:0] acc, input logic [7:0] d,
                                           input logic [7:0] p);
      logic [7:0] a;
      a = acc ^ d;
      for (int k = 0; k < 8; k++) a = a[7] ? ((a << 1) ^ p) : (a << 1);
      return a;
   endfunction

   function automatic logic [7:0] crc_one(input logic [7:0] acc, input logic b,
                                          input logic [7:0] p);
      return (acc[7] ^ b) ? ((acc << 1) ^ p) : (acc << 1);
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic summary();
      if (!done) begin
         done = 1'b1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   endtask

   // one serial bit; loopback with optional flip, or a fixed input level
   task automatic tick(input logic fixed, input logic val, input logic flip, output logic sent);
      @(negedge clk);
      sent = tx_bit;
      rx_bit = fixed ? val : (tx_bit ^ flip);
      bit_tick = 1'b1;
      @(negedge clk);
      bit_tick = 1'b0;
   endtask

   task automatic send_frame(input logic [7:0] flip, output logic [7:0] sent);
      logic b;
      for (int i = 7; i >= 0; i--) begin
         tick(1'b0, 1'b0, flip[i], b);
         sent[i] = b;
      end
   endtask

   task automatic pulse_read();
      rx_read = 1'b1;
      @(negedge clk);
      rx_read = 1'b0;
   endtask

   task automatic write_err(input logic v);
      err_wr = 1'b1;
      err_wdata = v;
      @(negedge clk);
      err_wr = 1'b0;
   endtask

   task automatic toggle_en();
      @(negedge clk);
      crc_en = 1'b0;
      @(negedge clk);
      crc_en = 1'b1;
   endtask

   // n data frames then the CRC frame; bad_f selects a corrupted frame (-1: none)
   task automatic run_txn(input int n, input logic [7:0] seed, input logic aut,
                          input int bad_f, input logic [7:0] bad_m, input logic [7:0] pol,
                          input logic do_clr, input logic [7:0] tx_pre, input logic [7:0] rx_pre,
                          input logic keep_err);
      logic [7:0] txc, rxc, d, fl, s;
      poly = pol;
      auto_mode = aut;
      tx_count = CNT_W'(n);
      if (do_clr) toggle_en();
      txc = tx_pre;
      rxc = rx_pre;
      for (int f = 0; f < n; f++) begin
         d = seed + 8'(f * 53);
         fl = (f == bad_f) ? bad_m : 8'h00;
         tx_data = d;
         if (!aut && f == n - 1) begin
            crc_next = 1'b1;
            @(negedge clk);
            crc_next = 1'b0;
         end
         send_frame(fl, s);
         chk("R5 data frame in rx_buf", rx_buf, d ^ fl);
         chk("R5 rx_ready after frame", rx_ready, 1);
         chk("R1 data bits sent", s, d);
         chk(f == n - 1 ? (aut ? "R3 crc frame follows count" : "R4 crc frame after request")
                        : "R3 no early crc frame", crc_frame, f == n - 1);
         pulse_read();
         txc = crc_byte(txc, d, pol);
         rxc = crc_byte(rxc, d ^ fl, pol);
      end
      send_frame(8'h00, s);
      chk("R2 transmitted crc frame", s, txc);
      chk("R5 crc frame in rx_buf", rx_buf, txc);
      chk("R6 crc_err after compare", crc_err, txc != rxc);
      chk("R2 crc_frame ends", crc_frame, 0);
      pulse_read();
      if (!keep_err) begin
         write_err(1'b0);
         chk("R7 error cleared by write 0", crc_err, 0);
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      summary();
   end

   initial begin
      logic b;
      logic [7:0] s, rxm, txm;
      repeat (3) @(negedge clk);
      // R11 reset state
      chk("R11 rx_buf reset", rx_buf, 0);
      chk("R11 rx_ready reset", rx_ready, 0);
      chk("R11 crc_err reset", crc_err, 0);
      chk("R11 crc_frame reset", crc_frame, 0);
      rst_n = 1'b1;
      spi_en = 1'b1;
      crc_en = 1'b1;

      // R1/R2/R3/R4: clean transfers over several polynomials and lengths
      foreach (poly_set[pi]) begin
         for (int n = 1; n <= 4; n++) begin
            run_txn(n, 8'(8'h11 * n + pi), 1'b1, -1, 8'h00, poly_set[pi], 1'b1, 8'h00, 8'h00, 1'b0);
            run_txn(n, 8'(8'hC3 ^ (n * 7)), 1'b0, -1, 8'h00, poly_set[pi], 1'b1, 8'h00, 8'h00, 1'b0);
         end
      end

      // R6: every single-bit corruption position over a three-frame transfer
      for (int bf = 0; bf < 3; bf++)
         for (int bp = 0; bp < 8; bp++)
            run_txn(3, 8'(8'h5A + bf * 8 + bp), 1'b1, bf, 8'(1 << bp), 8'h07, 1'b1,
                    8'h00, 8'h00, 1'b0);

      // R7: write of 1 leaves the flag set; write of 0 clears it
      run_txn(2, 8'h21, 1'b1, 1, 8'h10, 8'h07, 1'b1, 8'h00, 8'h00, 1'b1);
      chk("R6 corrupted transfer flags", crc_err, 1);
      write_err(1'b1);
      chk("R7 write 1 has no effect", crc_err, 1);
      repeat (4) @(negedge clk);
      chk("R7 flag holds", crc_err, 1);
      write_err(1'b0);
      chk("R7 write 0 clears", crc_err, 0);

      // R4: manual mode with no request inserts no crc frame
      auto_mode = 1'b0;
      tx_count = 8'd1;
      toggle_en();
      for (int f = 0; f < 3; f++) begin
         tx_data = 8'(8'h40 + f);
         send_frame(8'h00, s);
         chk("R4 no crc frame without request", crc_frame, 0);
         pulse_read();
      end

      // R5: ready holds until read
      tx_data = 8'h9E;
      send_frame(8'h00, s);
      repeat (6) @(negedge clk);
      chk("R5 ready holds", rx_ready, 1);
      pulse_read();
      chk("R5 read clears ready", rx_ready, 0);

      // R8: frames with stale accumulators, then re-enable resynchronises
      auto_mode = 1'b1;
      tx_count = 8'd200;
      tx_data = 8'h77;
      send_frame(8'h01, s);
      send_frame(8'h00, s);
      pulse_read();
      spi_en = 1'b0;
      @(negedge clk);
      spi_en = 1'b1;
      run_txn(2, 8'h3D, 1'b1, -1, 8'h00, 8'h07, 1'b1, 8'h00, 8'h00, 1'b0);
      chk("R8 clean after re-enable", crc_err, 0);

      // R10: disabled master ignores ticks
      toggle_en();
      spi_en = 1'b0;
      for (int k = 0; k < 5; k++) tick(1'b1, 1'b1, 1'b0, b);
      chk("R10 no frame while disabled", rx_ready, 0);
      spi_en = 1'b1;
      run_txn(2, 8'h6B, 1'b1, -1, 8'h00, 8'h07, 1'b0, 8'h00, 8'h00, 1'b0);
      chk("R10 crc ignores disabled ticks", crc_err, 0);

      // R9: slave calculator runs while deselected and while disabled
      slave_mode = 1'b1;
      cs_n = 1'b1;
      spi_en = 1'b0;
      tx_data = 8'h3C;
      toggle_en();
      rxm = 8'h00;
      txm = 8'h00;
      for (int k = 0; k < 3; k++) begin
         tick(1'b1, 1'b1, 1'b0, b);
         rxm = crc_one(rxm, 1'b1, 8'h07);
         txm = crc_one(txm, b, 8'h07);
      end
      spi_en = 1'b1;
      for (int k = 0; k < 3; k++) begin
         tick(1'b1, 1'b1, 1'b0, b);
         rxm = crc_one(rxm, 1'b1, 8'h07);
         txm = crc_one(txm, b, 8'h07);
      end
      chk("R9 no frame while deselected", rx_ready, 0);
      cs_n = 1'b0;
      run_txn(2, 8'h3C, 1'b1, -1, 8'h00, 8'h07, 1'b0, txm, rxm, 1'b1);
      chk("R9 deselected bits counted", crc_err, rxm != txm);
      write_err(1'b0);
      cs_n = 1'b1;
      slave_mode = 1'b0;

      summary();
   end

   logic [7:0] poly_set [4] = '{8'h07, 8'h31, 8'h1D, 8'h9B};

endmodule